// File: doc/BRIEF.md
# Timed Output Event Scheduler

This block holds a short list of pending timed commands and carries each one out when a reference timer reaches the command's time stamp. Software writes a command in one cycle. The command holds a time stamp, a 4-bit action code, a level bit, an interrupt-enable bit and a timer select. The command goes into a small associative store. The block does not compare the store continuously. A scan counter opens a compare window once every `SCAN_LEN` clock cycles. In that window every occupied slot checks its stamp against the timer it selected. A slot that hits carries out its action and becomes free.

An action can do one of four things: drive one of the output lines high or low, set a sticky software flag, pulse a timer-2 reset strobe, or pulse a conversion-start strobe. Line actions raise one interrupt pulse. Flag, timer-reset and conversion actions raise a second interrupt pulse. Each pulse appears only if a hitting command had its interrupt bit set. The two timers arrive as inputs; the block never counts them itself. When every slot is occupied, a busy output is high and further writes are dropped.

Top module: `evt_sched`

## Requirements
- R1: While reset is asserted, and until the first compare window, all lines, flags, strobes and interrupts are low and `cmd_busy` is low.
- R2: A write goes into the lowest-numbered free slot. `SLOTS` (8) writes fill the store and raise `cmd_busy`. A write made while `cmd_busy` is high is discarded and never acts.
- R3: Compare windows occur in every `SCAN_LEN`-th cycle after reset (8, 16, …). Effects appear in the cycle that follows a window, and every strobe and interrupt is high for exactly that one cycle.
- R4: A slot hits when its stamp equals `tmr1` (`cmd_tsel`=0) or `tmr2` (`cmd_tsel`=1) in a compare window. A stamp that equals only the unselected timer does not hit. A slot that hits becomes free.
- R5: Codes 0–5 drive `lines_o[code]` to `cmd_level`. The line holds that value until a later command changes it.
- R6: Codes 8–11 set `flags_o[code-8]`. A flag stays set until reset.
- R7: Code 14 pulses `t2_reset_o` and code 15 pulses `adc_start_o`.
- R8: `line_irq_o` pulses when a hitting command with code 0–5 has its interrupt bit set. `soft_irq_o` pulses for the same condition with codes 8–11, 14 or 15. A hit whose interrupt bit is clear raises no interrupt.
- R9: All slots that hit in one window act in that window. When two of them drive the same line, the higher-numbered slot decides the level.
- R10: Codes 6, 7, 12 and 13 free their slot and change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr | input | 1 | Command write strobe |
| cmd_time | input | TIME_W | Time stamp of the command |
| cmd_code | input | 4 | Action code |
| cmd_level | input | 1 | Level for line actions |
| cmd_irq_en | input | 1 | Request an interrupt when the command acts |
| cmd_tsel | input | 1 | Reference select: 0 = tmr1, 1 = tmr2 |
| tmr1 | input | TIME_W | Timer 1 value |
| tmr2 | input | TIME_W | Timer 2 value |
| cmd_busy | output | 1 | All slots occupied |
| lines_o | output | N_LINES | Scheduled output lines |
| flags_o | output | N_FLAGS | Sticky software flags |
| adc_start_o | output | 1 | Conversion start strobe |
| t2_reset_o | output | 1 | Timer 2 reset strobe |
| line_irq_o | output | 1 | Interrupt for line actions |
| soft_irq_o | output | 1 | Interrupt for flag, timer-reset and conversion actions |

## Verification
The properties rely on the reset and clock being clean and on `SCAN_LEN` being at least 2. Under those conditions a strobe can never appear in two cycles in a row. They also assume that `cmd_wr` is driven cleanly between clock edges. The stimulus changes every input only on the falling edge. It keeps `tmr1` counting upward from zero and sets `tmr2` to chosen constants, so each hit falls in a window the bench has predicted. Time stamps for commands that must stay pending are chosen well away from any value either timer reaches during the run.

// File: rtl/evt_sched_pkg.sv
package evt_sched_pkg;

   localparam int CODE_W = 4;

   localparam logic [CODE_W-1:0] OP_FLAG_BASE = 4'd8;
   localparam logic [CODE_W-1:0] OP_T2_RESET  = 4'd14;
   localparam logic [CODE_W-1:0] OP_ADC_START = 4'd15;

   typedef struct packed {
      logic [CODE_W-1:0] code;
      logic              level;
      logic              irq_en;
      logic              tsel;
   } slot_attr_t;

endpackage

// File: rtl/evt_free_pick.sv
module evt_free_pick #(
   parameter int SLOTS = 8
) (
   input  logic [SLOTS-1:0] valid_i,
   output logic [SLOTS-1:0] pick_o,
   output logic             full_o
);

   generate
      if (SLOTS == 1) begin : g_single
         assign pick_o = ~valid_i;
      end else begin : g_prio
         always_comb begin
            pick_o = '0;
            for (int s = SLOTS - 1; s >= 0; s--) begin
               if (!valid_i[s]) begin
                  pick_o    = '0;
                  pick_o[s] = 1'b1;
               end
            end
         end
      end
   endgenerate

   assign full_o = &valid_i;

endmodule

// File: rtl/evt_cam_match.sv
module evt_cam_match #(
   parameter int SLOTS  = 8,
   parameter int TIME_W = 16
) (
   input  logic                         scan_i,
   input  logic [SLOTS-1:0]             valid_i,
   input  logic [SLOTS-1:0][TIME_W-1:0] time_i,
   input  logic [SLOTS-1:0]             tsel_i,
   input  logic [TIME_W-1:0]            tmr1_i,
   input  logic [TIME_W-1:0]            tmr2_i,
   output logic [SLOTS-1:0]             hit_o
);

   for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
      logic [TIME_W-1:0] ref_time;
      assign ref_time  = tsel_i[g] ? tmr2_i : tmr1_i;
      assign hit_o[g]  = scan_i & valid_i[g] & (time_i[g] == ref_time);
   end

endmodule

// File: rtl/evt_action_merge.sv
module evt_action_merge
   import evt_sched_pkg::*;
#(
   parameter int SLOTS   = 8,
   parameter int N_LINES = 6,
   parameter int N_FLAGS = 4
) (
   input  logic [SLOTS-1:0]   hit_i,
   input  slot_attr_t [SLOTS-1:0] attr_i,
   input  logic [N_LINES-1:0] lines_i,
   output logic [N_LINES-1:0] lines_o,
   output logic [N_FLAGS-1:0] flag_set_o,
   output logic               adc_o,
   output logic               t2rst_o,
   output logic               irq_line_o,
   output logic               irq_soft_o
);

   always_comb begin
      lines_o    = lines_i;
      flag_set_o = '0;
      adc_o      = 1'b0;
      t2rst_o    = 1'b0;
      irq_line_o = 1'b0;
      irq_soft_o = 1'b0;
      for (int s = 0; s < SLOTS; s++) begin
         if (hit_i[s]) begin
            for (int l = 0; l < N_LINES; l++) begin
               if (attr_i[s].code == CODE_W'(l)) begin
                  lines_o[l] = attr_i[s].level;
                  irq_line_o = irq_line_o | attr_i[s].irq_en;
               end
            end
            for (int f = 0; f < N_FLAGS; f++) begin
               if (attr_i[s].code == OP_FLAG_BASE + CODE_W'(f)) begin
                  flag_set_o[f] = 1'b1;
                  irq_soft_o    = irq_soft_o | attr_i[s].irq_en;
               end
            end
            if (attr_i[s].code == OP_T2_RESET) begin
               t2rst_o    = 1'b1;
               irq_soft_o = irq_soft_o | attr_i[s].irq_en;
            end
            if (attr_i[s].code == OP_ADC_START) begin
               adc_o      = 1'b1;
               irq_soft_o = irq_soft_o | attr_i[s].irq_en;
            end
         end
      end
   end

endmodule

// File: rtl/evt_sched.sv
module evt_sched
   import evt_sched_pkg::*;
#(
   parameter int SLOTS    = 8,
   parameter int TIME_W   = 16,
   parameter int SCAN_LEN = 8,
   parameter int N_LINES  = 6,
   parameter int N_FLAGS  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_wr,
   input  logic [TIME_W-1:0]  cmd_time,
   input  logic [3:0]         cmd_code,
   input  logic               cmd_level,
   input  logic               cmd_irq_en,
   input  logic               cmd_tsel,
   input  logic [TIME_W-1:0]  tmr1,
   input  logic [TIME_W-1:0]  tmr2,
   output logic               cmd_busy,
   output logic [N_LINES-1:0] lines_o,
   output logic [N_FLAGS-1:0] flags_o,
   output logic               adc_start_o,
   output logic               t2_reset_o,
   output logic               line_irq_o,
   output logic               soft_irq_o
);

   localparam int CNT_W = $clog2(SCAN_LEN);

   if (SLOTS < 1)                   begin : g_bad_slots $error("SLOTS must be at least 1"); end
   if (SCAN_LEN < 2)                begin : g_bad_scan  $error("SCAN_LEN must be at least 2"); end
   if (N_LINES < 1 || N_LINES > 6)  begin : g_bad_lines $error("N_LINES must be 1..6"); end
   if (N_FLAGS < 1 || N_FLAGS > 4)  begin : g_bad_flags $error("N_FLAGS must be 1..4"); end
   if (TIME_W < 2)                  begin : g_bad_time  $error("TIME_W must be at least 2"); end

   logic [CNT_W-1:0]              cnt_q;
   logic                          scan_tick;
   logic [SLOTS-1:0]              valid_q;
   logic [SLOTS-1:0][TIME_W-1:0]  time_q;
   slot_attr_t [SLOTS-1:0]        attr_q;
   logic [SLOTS-1:0]              tsel_v;
   logic [SLOTS-1:0]              pick;
   logic [SLOTS-1:0]              hit;
   logic                          full;
   logic                          wr_ok;
   logic [N_LINES-1:0]            lines_nxt;
   logic [N_FLAGS-1:0]            flag_set;
   logic                          adc_nxt, t2_nxt, irql_nxt, irqs_nxt;
   slot_attr_t                    new_attr;

   assign scan_tick = (cnt_q == CNT_W'(SCAN_LEN - 1));
   assign wr_ok     = cmd_wr & ~full;
   assign cmd_busy  = full;
   assign new_attr  = '{code: cmd_code, level: cmd_level, irq_en: cmd_irq_en, tsel: cmd_tsel};

   for (genvar g = 0; g < SLOTS; g++) begin : g_tsel
      assign tsel_v[g] = attr_q[g].tsel;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (scan_tick) cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
   end

   evt_free_pick #(.SLOTS(SLOTS)) u_pick (
      .valid_i (valid_q),
      .pick_o  (pick),
      .full_o  (full)
   );

   evt_cam_match #(.SLOTS(SLOTS), .TIME_W(TIME_W)) u_match (
      .scan_i  (scan_tick),
      .valid_i (valid_q),
      .time_i  (time_q),
      .tsel_i  (tsel_v),
      .tmr1_i  (tmr1),
      .tmr2_i  (tmr2),
      .hit_o   (hit)
   );

   evt_action_merge #(.SLOTS(SLOTS), .N_LINES(N_LINES), .N_FLAGS(N_FLAGS)) u_merge (
      .hit_i      (hit),
      .attr_i     (attr_q),
      .lines_i    (lines_o),
      .lines_o    (lines_nxt),
      .flag_set_o (flag_set),
      .adc_o      (adc_nxt),
      .t2rst_o    (t2_nxt),
      .irq_line_o (irql_nxt),
      .irq_soft_o (irqs_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         time_q  <= '0;
         attr_q  <= '0;
      end else begin
         for (int s = 0; s < SLOTS; s++) begin
            if (hit[s]) begin
               valid_q[s] <= 1'b0;
            end else if (wr_ok && pick[s]) begin
               valid_q[s] <= 1'b1;
               time_q[s]  <= cmd_time;
               attr_q[s]  <= new_attr;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lines_o     <= '0;
         flags_o     <= '0;
         adc_start_o <= 1'b0;
         t2_reset_o  <= 1'b0;
         line_irq_o  <= 1'b0;
         soft_irq_o  <= 1'b0;
      end else begin
         lines_o     <= lines_nxt;
         flags_o     <= flags_o | flag_set;
         adc_start_o <= adc_nxt;
         t2_reset_o  <= t2_nxt;
         line_irq_o  <= irql_nxt;
         soft_irq_o  <= irqs_nxt;
      end
   end

endmodule

// File: rtl/evt_sched_chk.sv
module evt_sched_chk #(
   parameter int SLOTS    = 8,
   parameter int SCAN_LEN = 8,
   parameter int N_LINES  = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_busy,
   input logic [N_LINES-1:0] lines_o,
   input logic               adc_start_o,
   input logic               t2_reset_o,
   input logic               line_irq_o,
   input logic               soft_irq_o,
   input logic               scan_tick,
   input logic [SLOTS-1:0]   valid_q
);

   localparam int PH_W = $clog2(SCAN_LEN);

   logic [PH_W-1:0] ph_q;
   logic            any_pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                ph_q <= '0;
      else if (ph_q == PH_W'(SCAN_LEN - 1))      ph_q <= '0;
      else                                       ph_q <= ph_q + 1'b1;
   end

   assign any_pulse = adc_start_o | t2_reset_o | line_irq_o | soft_irq_o;

   assert_tick_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
      scan_tick |-> ph_q == PH_W'(SCAN_LEN - 1));

   assert_pulse_after_scan_R3: assert property (@(posedge clk) disable iff (!rst_n)
      any_pulse |-> ph_q == '0);

   assert_lines_after_scan_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lines_o) |-> ph_q == '0);

   assert_adc_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start_o |=> !adc_start_o);

   assert_t2_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      t2_reset_o |=> !t2_reset_o);

   assert_full_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_busy && !scan_tick) |=> cmd_busy);

   assert_free_at_scan_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(valid_q) < $past($countones(valid_q))) |-> ph_q == '0);

endmodule

bind evt_sched evt_sched_chk #(
   .SLOTS    (SLOTS),
   .SCAN_LEN (SCAN_LEN),
   .N_LINES  (N_LINES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_busy    (cmd_busy),
   .lines_o     (lines_o),
   .adc_start_o (adc_start_o),
   .t2_reset_o  (t2_reset_o),
   .line_irq_o  (line_irq_o),
   .soft_irq_o  (soft_irq_o),
   .scan_tick   (scan_tick),
   .valid_q     (valid_q)
);

// File: tb/evt_sched_bench.sv
`timescale 1ns/1ps
module evt_sched_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr = 1'b0;
   logic [15:0] cmd_time = '0;
   logic [3:0]  cmd_code = '0;
   logic        cmd_level = 1'b0;
   logic        cmd_irq_en = 1'b0;
   logic        cmd_tsel = 1'b0;
   logic [15:0] tmr1 = '0;
   logic [15:0] tmr2 = 16'h5555;
   logic        cmd_busy;
   logic [5:0]  lines_o;
   logic [3:0]  flags_o;
   logic        adc_start_o, t2_reset_o, line_irq_o, soft_irq_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   evt_sched u_evt_sched (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_time(cmd_time),
      .cmd_code(cmd_code), .cmd_level(cmd_level), .cmd_irq_en(cmd_irq_en),
      .cmd_tsel(cmd_tsel), .tmr1(tmr1), .tmr2(tmr2), .cmd_busy(cmd_busy),
      .lines_o(lines_o), .flags_o(flags_o), .adc_start_o(adc_start_o),
      .t2_reset_o(t2_reset_o), .line_irq_o(line_irq_o), .soft_irq_o(soft_irq_o)
   );

   // behavioural reference
   logic [15:0] m_time [8];
   int          m_code [8];
   bit          m_lvl [8], m_irq [8], m_tsel [8], m_valid [8];
   logic [5:0]  m_lines;
   logic [3:0]  m_flags;
   bit          m_adc, m_t2, m_il, m_is;
   int          m_cnt, m_free, m_c;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) m_valid[i] = 0;
         m_lines = '0; m_flags = '0; m_cnt = 0;
         m_adc = 0; m_t2 = 0; m_il = 0; m_is = 0;
      end else begin
         m_free = -1;
         for (int i = 0; i < 8; i++) if (!m_valid[i] && m_free < 0) m_free = i;
         m_adc = 0; m_t2 = 0; m_il = 0; m_is = 0;
         if (m_cnt == 7) begin
            for (int i = 0; i < 8; i++) begin
               if (m_valid[i] && m_time[i] == (m_tsel[i] ? tmr2 : tmr1)) begin
                  m_c = m_code[i];
                  if (m_c <= 5) begin m_lines[m_c] = m_lvl[i]; m_il = m_il | m_irq[i]; end
                  else if (m_c >= 8 && m_c <= 11) begin m_flags[m_c-8] = 1'b1; m_is = m_is | m_irq[i]; end
                  else if (m_c == 14) begin m_t2 = 1; m_is = m_is | m_irq[i]; end
                  else if (m_c == 15) begin m_adc = 1; m_is = m_is | m_irq[i]; end
                  m_valid[i] = 0;
               end
            end
         end
         if (cmd_wr && m_free >= 0) begin
            m_valid[m_free] = 1; m_time[m_free] = cmd_time; m_code[m_free] = int'(cmd_code);
            m_lvl[m_free] = cmd_level; m_irq[m_free] = cmd_irq_en; m_tsel[m_free] = cmd_tsel;
         end
         m_cnt = (m_cnt + 1) % 8;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit m_full();
      for (int i = 0; i < 8; i++) if (!m_valid[i]) return 0;
      return 1;
   endfunction

   task automatic cyc();
      @(negedge clk);
      chk("R3 model lines", 32'(lines_o), 32'(m_lines));
      chk("R6 model flags", 32'(flags_o), 32'(m_flags));
      chk("R7 model strobes", {30'd0, adc_start_o, t2_reset_o}, {30'd0, m_adc, m_t2});
      chk("R8 model irqs", {30'd0, line_irq_o, soft_irq_o}, {30'd0, m_il, m_is});
      chk("R2 model busy", 32'(cmd_busy), 32'(m_full()));
      tmr1 = tmr1 + 16'd1;
   endtask

   task automatic load(input logic [15:0] t, input logic [3:0] code, input bit lvl, input bit irq, input bit tsel);
      cmd_wr = 1; cmd_time = t; cmd_code = code; cmd_level = lvl; cmd_irq_en = irq; cmd_tsel = tsel;
      cyc();
      cmd_wr = 0;
   endtask

   task automatic wait_scan();
      do cyc(); while (m_cnt != 0);
   endtask

   initial begin
      #(8ns * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] tgt;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 lines", 32'(lines_o), 0);
      chk("R1 flags", 32'(flags_o), 0);
      chk("R1 busy", 32'(cmd_busy), 0);
      chk("R1 pulses", {28'd0, adc_start_o, t2_reset_o, line_irq_o, soft_irq_o}, 0);
      rst_n = 1;
      repeat (4) cyc();
      chk("R1 idle after reset", {26'd0, lines_o}, 0);

      // R5/R8: set line 3 with interrupt
      load(16'h5555, 4'd3, 1, 1, 1);
      wait_scan();
      chk("R5 line set", 32'(lines_o), 32'h08);
      chk("R8 line irq", 32'(line_irq_o), 1);
      cyc();
      chk("R3 irq one cycle", 32'(line_irq_o), 0);
      chk("R5 line held", 32'(lines_o), 32'h08);

      // R5 clear, R8 no irq
      load(16'h5555, 4'd3, 0, 0, 1);
      wait_scan();
      chk("R5 line clear", 32'(lines_o), 0);
      chk("R8 no irq", 32'(line_irq_o), 0);

      // R6 flag
      load(16'h5555, 4'd9, 0, 1, 1);
      wait_scan();
      chk("R6 flag set", 32'(flags_o), 32'h2);
      chk("R8 soft irq", 32'(soft_irq_o), 1);
      wait_scan();
      chk("R6 flag sticky", 32'(flags_o), 32'h2);

      // R7 strobes
      load(16'h5555, 4'd15, 0, 0, 1);
      wait_scan();
      chk("R7 adc start", {30'd0, adc_start_o, t2_reset_o}, 32'h2);
      cyc();
      chk("R7 adc one cycle", 32'(adc_start_o), 0);
      load(16'h5555, 4'd14, 0, 1, 1);
      wait_scan();
      chk("R7 t2 reset", {30'd0, adc_start_o, t2_reset_o}, 32'h1);
      chk("R8 soft irq t2", 32'(soft_irq_o), 1);

      // R10 reserved codes
      load(16'h5555, 4'd7, 1, 1, 1);
      load(16'h5555, 4'd12, 1, 1, 1);
      wait_scan();
      wait_scan();
      chk("R10 no output", {22'd0, lines_o, flags_o}, 32'h002);
      chk("R10 no pulses", {28'd0, adc_start_o, t2_reset_o, line_irq_o, soft_irq_o}, 0);
      chk("R10 slots freed", 32'(cmd_busy), 0);

      // R9 simultaneous hits, higher slot wins
      load(16'h1234, 4'd2, 1, 0, 1);
      load(16'h1234, 4'd2, 0, 0, 1);
      load(16'h1234, 4'd1, 1, 0, 1);
      tmr2 = 16'h1234;
      wait_scan();
      chk("R9 later slot clears", 32'(lines_o), 32'h02);
      tmr2 = 16'h5555;
      load(16'h1235, 4'd2, 0, 0, 1);
      load(16'h1235, 4'd2, 1, 0, 1);
      tmr2 = 16'h1235;
      wait_scan();
      chk("R9 later slot sets", 32'(lines_o), 32'h06);
      tmr2 = 16'h5555;
      cyc();

      // R2 fill and reject, R4 release
      for (int k = 0; k < 7; k++) load(16'hAAAA, 4'd0, 1, 0, 1);
      chk("R2 seven not busy", 32'(cmd_busy), 0);
      load(16'hAAAA, 4'd0, 1, 0, 1);
      chk("R2 eight busy", 32'(cmd_busy), 1);
      load(16'h5555, 4'd4, 1, 0, 1);
      wait_scan();
      chk("R2 rejected write", 32'(lines_o[4]), 0);
      chk("R2 still busy", 32'(cmd_busy), 1);
      tmr2 = 16'hAAAA;
      wait_scan();
      chk("R4 all fired", 32'(lines_o), 32'h07);
      chk("R4 slots freed", 32'(cmd_busy), 0);
      tmr2 = 16'h5555;

      // R4 timer select
      tgt = tmr1 + 16'((7 - m_cnt) % 8) + 16'd8;
      load(tgt, 4'd5, 1, 0, 1);
      tgt = tgt + 16'd0;
      tmr1 = tmr1;
      begin
         logic [15:0] t1;
         t1 = tmr1 + 16'((7 - m_cnt) % 8) + 16'd8;
         load(t1, 4'd4, 1, 0, 0);
      end
      repeat (40) cyc();
      chk("R4 tmr1 hit", 32'(lines_o[4]), 1);
      chk("R4 unselected timer ignored", 32'(lines_o[5]), 0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule